// File: doc/BRIEF.md
# Shadow-Tag Snoop Responder

This block holds a private copy of one processor's first-level cache directory: a tag and a line state for every set. The copy sits in the interconnect clock domain. When the interconnect broadcasts a coherence probe, the block looks the line up in its copy and answers with the line's status. It never uses the processor's own tag port for this. If the probe requires the processor to give up the line or return dirty data, the block issues a command towards the processor side and moves its copy to the new state.

Each line follows the three-state Invalid / Shared / Modified discipline. The block takes one probe per clock cycle through a fixed two-stage pipeline. A separate update channel mirrors the processor's own fills, upgrades and evictions into the copy. Caches are direct-mapped, with 64 sets of 128-byte lines by default.

Top module: `shadowSnoopResponder`

## Requirements
- R1: An address splits into a 7-bit byte offset (bits 6:0), a 6-bit set index (bits 12:7) and a tag in the remaining upper bits. A probe hits only when the stored state of its set is not Invalid and the stored tag equals the probe's tag.
- R2: Line states are encoded 00 Invalid, 01 Shared, 10 Modified. An update with `updValid` high writes the tag of `updAddr` and the state `updState` into that set at the next clock edge, so an eviction is an update to 00. After reset every set is Invalid and no response or command is valid.
- R3: A probe can be presented on every cycle. Its response appears with `rspValid` high exactly two rising edges after the edge that samples it, and in no other cycle.
- R4: `rspStatus` reports the line's state as it was before the probe: 00 miss, 01 hit Shared, 10 hit Modified. The code 11 never appears.
- R5: A shared-read probe (`snpExcl` low) that hits a Modified line gives a command with write-back and without invalidate, and the line becomes Shared.
- R6: A shared-read probe that hits a Shared line gives no command, and the line stays Shared.
- R7: An exclusive probe (`snpExcl` high) that hits a Modified line gives a command with both write-back and invalidate, and the line becomes Invalid.
- R8: An exclusive probe that hits a Shared line gives an invalidate command without write-back, and the line becomes Invalid.
- R9: A probe that misses gives no command and leaves the stored entry unchanged, including a valid entry holding a different tag.
- R10: A probe that changes a line writes that set at the same edge that registers its response, so the very next probe sees the result. If a processor update to the same set is applied at that edge, the probe's result wins: the set ends up holding the probe's tag and the probe's new state.
- R11: `cmdAddr` carries the probed line's tag and index, with the offset bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rstN | input | 1 | Active-low synchronous reset |
| snpValid | input | 1 | Probe present this cycle |
| snpAddr | input | 32 | Probe byte address |
| snpExcl | input | 1 | 1 = exclusive ownership, 0 = shared read |
| updValid | input | 1 | Processor-side directory update present |
| updAddr | input | 32 | Address of the updated line |
| updState | input | 2 | New state of that line (00/01/10) |
| rspValid | output | 1 | Probe response valid |
| rspStatus | output | 2 | Line status before the probe |
| cmdValid | output | 1 | Command to the processor side valid |
| cmdAddr | output | 32 | Line address for the command |
| cmdWriteBack | output | 1 | Processor must write back the dirty line |
| cmdInvalidate | output | 1 | Processor must drop the line |

## Verification
The assertions assume that `updState` never carries the unused code 11. They also assume that the update channel describes the processor's real directory, so a stored state is always one of the three legal codes. The latency and command-shape properties compare outputs against inputs sampled two edges earlier, which relies on the probe inputs being held stable between edges. The stimulus draws `updState` only from the three legal codes. It drives every input on the falling edge, and it takes addresses from a small pool of tags and sets. This keeps hits, tag conflicts, back-to-back probes to one set and same-set update collisions frequent.

// File: rtl/shadowSnoopPkg.sv
package shadowSnoopPkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'b00,
    LINE_SHR = 2'b01,
    LINE_MOD = 2'b10
  } lineState_e;

  typedef enum logic [1:0] {
    RSP_MISS = 2'b00,
    RSP_SHR  = 2'b01,
    RSP_MOD  = 2'b10
  } rspCode_e;

  // Strobes from the control decision to the datapath registers
  typedef struct packed {
    logic       rspValid;
    logic [1:0] rspCode;
    logic       cmdValid;
    logic       doWriteBack;
    logic       doInvalidate;
    logic       stateWrite;
    logic [1:0] nextState;
  } snpStrobe_t;

endpackage

// File: rtl/snoopCtrl.sv
module snoopCtrl
  import shadowSnoopPkg::*;
(
  input  logic       lookValid,
  input  logic       lookExcl,
  input  logic       lookHit,
  input  logic [1:0] lookState,
  output snpStrobe_t strb
);

  always_comb begin
    strb          = '0;
    strb.rspValid = lookValid;
    strb.rspCode  = RSP_MISS;
    if (lookValid && lookHit) begin
      strb.rspCode = (lookState == LINE_MOD) ? RSP_MOD : RSP_SHR;
      if (lookExcl) begin
        // ownership request: the line leaves this cache, dirty data returns first
        strb.cmdValid     = 1'b1;
        strb.doInvalidate = 1'b1;
        strb.doWriteBack  = (lookState == LINE_MOD);
        strb.stateWrite   = 1'b1;
        strb.nextState    = LINE_INV;
      end else if (lookState == LINE_MOD) begin
        // shared read of dirty line: supply data, keep a clean copy
        strb.cmdValid    = 1'b1;
        strb.doWriteBack = 1'b1;
        strb.stateWrite  = 1'b1;
        strb.nextState   = LINE_SHR;
      end
    end
  end

endmodule

// File: rtl/shadowTagPath.sv
module shadowTagPath
  import shadowSnoopPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpExcl,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [1:0]        updState,
  input  snpStrobe_t        strb,
  output logic              lookValid,
  output logic              lookExcl,
  output logic              lookHit,
  output logic [1:0]        lookState,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdWriteBack,
  output logic              cmdInvalidate
);

  localparam int OFFSET_W = $clog2(LINE_BYTES);
  localparam int INDEX_W  = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - INDEX_W - OFFSET_W;

  // Stage 1: registered probe
  logic              s1Valid;
  logic              s1Excl;
  logic [ADDR_W-1:0] s1Addr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Excl  <= 1'b0;
      s1Addr  <= '0;
    end else begin
      s1Valid <= snpValid;
      s1Excl  <= snpExcl;
      s1Addr  <= snpAddr;
    end
  end

  logic [INDEX_W-1:0] s1Idx;
  logic [TAG_W-1:0]   s1Tag;
  logic [INDEX_W-1:0] updIdx;
  logic [TAG_W-1:0]   updTag;

  assign s1Idx  = s1Addr[OFFSET_W +: INDEX_W];
  assign s1Tag  = s1Addr[ADDR_W-1 -: TAG_W];
  assign updIdx = updAddr[OFFSET_W +: INDEX_W];
  assign updTag = updAddr[ADDR_W-1 -: TAG_W];

  // Shadow directory
  logic [TAG_W-1:0] tagArr   [SETS];
  logic [1:0]       stateArr [SETS];

  assign lookValid = s1Valid;
  assign lookExcl  = s1Excl;
  assign lookState = stateArr[s1Idx];
  assign lookHit   = s1Valid && (stateArr[s1Idx] != LINE_INV) && (tagArr[s1Idx] == s1Tag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        tagArr[s]   <= '0;
        stateArr[s] <= LINE_INV;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (strb.stateWrite && (s1Idx == INDEX_W'(s))) begin
          // probe result overrides a same-set processor update
          tagArr[s]   <= s1Tag;
          stateArr[s] <= strb.nextState;
        end else if (updValid && (updIdx == INDEX_W'(s))) begin
          tagArr[s]   <= updTag;
          stateArr[s] <= updState;
        end
      end
    end
  end

  // Stage 2: response and command registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspStatus     <= RSP_MISS;
      cmdValid      <= 1'b0;
      cmdAddr       <= '0;
      cmdWriteBack  <= 1'b0;
      cmdInvalidate <= 1'b0;
    end else begin
      rspValid      <= strb.rspValid;
      rspStatus     <= strb.rspCode;
      cmdValid      <= strb.cmdValid;
      cmdAddr       <= {s1Addr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
      cmdWriteBack  <= strb.doWriteBack;
      cmdInvalidate <= strb.doInvalidate;
    end
  end

  // R2: directory never holds the unused state code
  p_state_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |-> (lookState != 2'b11));

  // R10: a probe write lands in its set with its tag, whatever the update did
  p_snoop_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.stateWrite |=> (stateArr[$past(s1Idx)] == $past(strb.nextState))
                        && (tagArr[$past(s1Idx)] == $past(s1Tag)));

endmodule

// File: rtl/shadowSnoopResponder.sv
module shadowSnoopResponder
  import shadowSnoopPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpExcl,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [1:0]        updState,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdWriteBack,
  output logic              cmdInvalidate
);

  localparam int OFFSET_W = $clog2(LINE_BYTES);

  snpStrobe_t strb;
  logic       lookValid;
  logic       lookExcl;
  logic       lookHit;
  logic [1:0] lookState;

  shadowTagPath #(
    .ADDR_W     (ADDR_W),
    .SETS       (SETS),
    .LINE_BYTES (LINE_BYTES)
  ) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .snpValid      (snpValid),
    .snpAddr       (snpAddr),
    .snpExcl       (snpExcl),
    .updValid      (updValid),
    .updAddr       (updAddr),
    .updState      (updState),
    .strb          (strb),
    .lookValid     (lookValid),
    .lookExcl      (lookExcl),
    .lookHit       (lookHit),
    .lookState     (lookState),
    .rspValid      (rspValid),
    .rspStatus     (rspStatus),
    .cmdValid      (cmdValid),
    .cmdAddr       (cmdAddr),
    .cmdWriteBack  (cmdWriteBack),
    .cmdInvalidate (cmdInvalidate)
  );

  snoopCtrl u_ctrl (
    .lookValid (lookValid),
    .lookExcl  (lookExcl),
    .lookHit   (lookHit),
    .lookState (lookState),
    .strb      (strb)
  );

  logic [ADDR_W-OFFSET_W-1:0] snpLine;
  assign snpLine = snpAddr[ADDR_W-1:OFFSET_W];

  // R3: one response per probe, two edges later
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(snpValid, 2));

  // R4: unused response code never produced
  p_rsp_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspStatus != 2'b11));

  // R5/R6: a shared read never invalidates
  p_read_no_inv_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(snpValid, 2) && !$past(snpExcl, 2)) |-> !(cmdValid && cmdInvalidate));

  // R7/R8: an exclusive probe that hits always invalidates
  p_excl_inv_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspStatus != RSP_MISS) && $past(snpExcl, 2)) |-> (cmdValid && cmdInvalidate));

  // R9: a miss is silent
  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspStatus == RSP_MISS)) |-> !cmdValid);

  // R11: command names the probed line
  p_cmd_addr_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdAddr[ADDR_W-1:OFFSET_W] == $past(snpLine, 2)));

endmodule

// File: tb/shadowSnoopResponder_tb.sv
`timescale 1ns/1ps
module shadowSnoopResponder_tb;

  localparam int AW = 32;
  localparam int NSETS = 64;
  localparam int OFFW = 7;
  localparam int IDXW = 6;
  localparam int TAGW = AW - IDXW - OFFW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          snpValid = 1'b0;
  logic [AW-1:0] snpAddr = '0;
  logic          snpExcl = 1'b0;
  logic          updValid = 1'b0;
  logic [AW-1:0] updAddr = '0;
  logic [1:0]    updState = 2'b00;
  logic          rspValid;
  logic [1:0]    rspStatus;
  logic          cmdValid;
  logic [AW-1:0] cmdAddr;
  logic          cmdWriteBack;
  logic          cmdInvalidate;

  int nChecks = 0;
  int nFails  = 0;
  bit chkOn   = 1'b0;

  always #2.5 clk = ~clk;

  shadowSnoopResponder u_dut (
    .clk (clk), .rstN (rstN),
    .snpValid (snpValid), .snpAddr (snpAddr), .snpExcl (snpExcl),
    .updValid (updValid), .updAddr (updAddr), .updState (updState),
    .rspValid (rspValid), .rspStatus (rspStatus),
    .cmdValid (cmdValid), .cmdAddr (cmdAddr),
    .cmdWriteBack (cmdWriteBack), .cmdInvalidate (cmdInvalidate)
  );

  function automatic logic [AW-1:0] mkAddr(input logic [TAGW-1:0] t, input int idx, input int off);
    return {t, IDXW'(idx), OFFW'(off)};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Specification model: tag/state copy and one-stage probe register
  logic [TAGW-1:0] mTag [NSETS];
  logic [1:0]      mSt  [NSETS];
  logic            pV, pX;
  logic [AW-1:0]   pA;
  logic            eRspV, eCmdV, eWb, eInv;
  logic [1:0]      eRsp;
  logic [AW-1:0]   eCmdA;
  string           eReq;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSETS; s++) begin mTag[s] = '0; mSt[s] = 2'b00; end
      pV = 0; pX = 0; pA = '0;
      eRspV = 0; eCmdV = 0; eWb = 0; eInv = 0; eRsp = 0; eCmdA = '0; eReq = "R2";
    end else begin
      int idx;
      logic [TAGW-1:0] tg;
      logic hit, wr;
      logic [1:0] nxt;
      idx = int'(pA[OFFW +: IDXW]);
      tg  = pA[AW-1 -: TAGW];
      hit = pV && mSt[idx] != 2'b00 && mTag[idx] == tg;
      wr = 0; nxt = 2'b00;
      eRspV = pV; eRsp = 2'b00; eCmdV = 0; eWb = 0; eInv = 0;
      eCmdA = {pA[AW-1:OFFW], {OFFW{1'b0}}};
      eReq = "R3";
      if (pV && !hit) eReq = (mSt[idx] != 2'b00) ? "R1" : "R9";
      if (hit) begin
        eRsp = mSt[idx];
        if (pX) begin
          eCmdV = 1; eInv = 1; eWb = (mSt[idx] == 2'b10); wr = 1; nxt = 2'b00;
          eReq = eWb ? "R7" : "R8";
        end else if (mSt[idx] == 2'b10) begin
          eCmdV = 1; eWb = 1; wr = 1; nxt = 2'b01; eReq = "R5";
        end else eReq = "R6";
      end
      if (updValid) begin
        if (wr && int'(updAddr[OFFW +: IDXW]) == idx) eReq = "R10";
        mTag[updAddr[OFFW +: IDXW]] = updAddr[AW-1 -: TAGW];
        mSt[updAddr[OFFW +: IDXW]]  = updState;
      end
      if (wr) begin mTag[idx] = tg; mSt[idx] = nxt; end
      pV = snpValid; pX = snpExcl; pA = snpAddr;
    end
  end

  // Compare at the falling edge, after the rising edge settled both sides
  always @(negedge clk) begin
    if (chkOn) begin
      check("R3 rspValid", AW'(rspValid), AW'(eRspV));
      if (eRspV) check({"R4 rspStatus ", eReq}, AW'(rspStatus), AW'(eRsp));
      check({"cmdValid ", eReq}, AW'(cmdValid), AW'(eCmdV));
      if (eCmdV) begin
        check({"cmdWriteBack ", eReq}, AW'(cmdWriteBack), AW'(eWb));
        check({"cmdInvalidate ", eReq}, AW'(cmdInvalidate), AW'(eInv));
        check("R11 cmdAddr", cmdAddr, eCmdA);
      end
    end
  end

  task automatic step(input logic sv, input logic [AW-1:0] sa, input logic sx,
                      input logic uv, input logic [AW-1:0] ua, input logic [1:0] us);
    @(negedge clk);
    snpValid <= sv; snpAddr <= sa; snpExcl <= sx;
    updValid <= uv; updAddr <= ua; updState <= us;
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0, 2'b00);
  endtask

  initial begin
    logic [TAGW-1:0] tA, tB, tC, tD;
    tA = 19'h01234; tB = 19'h05a5a; tC = 19'h00777; tD = 19'h7ffff;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN <= 1'b1;
    @(negedge clk);
    // R2: reset state of the outputs
    check("R2 reset rspValid", AW'(rspValid), '0);
    check("R2 reset cmdValid", AW'(cmdValid), '0);
    chkOn = 1'b1;
    // R2: every set empty after reset
    step(1, mkAddr(tA, 5, 0), 0, 0, '0, 0);
    step(1, mkAddr(tB, 63, 0), 1, 0, '0, 0);
    // R5, R6, R8, R9 on one line
    step(0, '0, 0, 1, mkAddr(tA, 5, 0), 2'b10);
    step(1, mkAddr(tA, 5, 7'h44), 0, 0, '0, 0);
    idle();
    step(1, mkAddr(tA, 5, 0), 0, 0, '0, 0);
    step(1, mkAddr(tA, 5, 0), 1, 0, '0, 0);
    step(1, mkAddr(tA, 5, 0), 0, 0, '0, 0);
    // R7 then back-to-back probe to same set (R10)
    step(0, '0, 0, 1, mkAddr(tB, 9, 0), 2'b10);
    step(1, mkAddr(tB, 9, 7'h7f), 1, 0, '0, 0);
    step(1, mkAddr(tB, 9, 0), 1, 0, '0, 0);
    idle();
    // R10: probe result overrides same-edge update
    step(0, '0, 0, 1, mkAddr(tC, 12, 0), 2'b10);
    step(1, mkAddr(tC, 12, 0), 0, 0, '0, 0);
    step(0, '0, 0, 1, mkAddr(tD, 12, 0), 2'b10);
    step(1, mkAddr(tD, 12, 0), 0, 0, '0, 0);
    step(1, mkAddr(tC, 12, 0), 0, 0, '0, 0);
    // R1 / R9: tag mismatch leaves the entry intact
    step(0, '0, 0, 1, mkAddr(tA, 20, 0), 2'b01);
    step(1, mkAddr(tB, 20, 0), 1, 0, '0, 0);
    step(1, mkAddr(tA, 20, 0), 0, 0, '0, 0);
    idle(); idle(); idle();
    // Random traffic over a small tag/set pool
    for (int i = 0; i < 4000; i++) begin
      logic [TAGW-1:0] pool [4];
      pool[0] = tA; pool[1] = tB; pool[2] = tC; pool[3] = tD;
      step(($urandom % 10) < 7, mkAddr(pool[$urandom % 4], int'($urandom % 8), int'($urandom % 128)),
           $urandom % 2,
           ($urandom % 10) < 3, mkAddr(pool[$urandom % 4], int'($urandom % 8), 0),
           2'($urandom % 3));
    end
    idle(); idle(); idle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule